// File: doc/BRIEF.md
# Tile-Walking Triangle Coverage Scanner

This block takes one triangle that has already been set up, in the form of three edge functions E(x,y) = A·x + B·y + C with signed fixed-point coefficients, together with its bounding box counted in whole tiles. It walks the screen tiles the triangle may touch and emits, for each tile it keeps, the tile's coordinates and a 32-bit map of which pixels lie inside. A tile is 8 pixels wide and 4 rows tall, so pixel (col,row) of tile (tx,ty) sits at screen position (8·tx+col, 4·ty+row).

Each tile row is walked outward from a start tile. The walk goes right until a tile lies outside the triangle or the box edge is reached, then goes left from the tile just left of the start under the same rule. The next row begins below the last tile kept in the row just finished. Kept tiles have their pixels evaluated column by column, from left to right, with a single addition of A per column step and of B per row step.

The triangle enters through a valid/ready handshake and tiles leave through another. A new triangle is taken only once the last tile of the current one has left.

Top module: `tile_raster`

## Requirements
- R1: Bit index row·8+col of a tile's map is 1 exactly when all three edge functions are >= 0 at pixel (8·tx+col, 4·ty+row); bit 0 is the top-left pixel.
- R2: A tile is dropped only when, for some edge, the function is negative at all four corner pixels (columns 0 and 7, rows 0 and 3); any other tile visited is emitted, even with an all-zero map.
- R3: The walk begins in tile row bb_y0 at column top_tx, clamped into [bb_x0, bb_x1].
- R4: In each row, tiles are emitted going right from the start column up to the first dropped tile or bb_x1, then going left from start column minus one down to the first dropped tile or bb_x0.
- R5: The start column of the next row is the column of the last tile emitted in the current row; if the row emitted none, the start column is kept.
- R6: Rows bb_y0 through bb_y1 are walked in order; no emitted tile lies outside the bounding box, and the walk ends after row bb_y1.
- R7: in_ready is low from the cycle after a triangle is accepted until its final tile has been handed off; input changes in that time have no effect.
- R8: While out_valid is high and out_ready is low, out_valid, out_tx, out_ty and out_mask hold their values.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Triangle offered |
| in_ready | output | 1 | Block idle, triangle can be taken |
| coef_a | input | 3·CW | x coefficients, edge k in bits [k·CW +: CW], signed |
| coef_b | input | 3·CW | y coefficients, same packing |
| coef_c | input | 3·CW | constant terms, same packing |
| bb_x0 | input | TXW | Leftmost tile column of the box |
| bb_y0 | input | TYW | Top tile row of the box |
| bb_x1 | input | TXW | Rightmost tile column (>= bb_x0) |
| bb_y1 | input | TYW | Bottom tile row (>= bb_y0) |
| top_tx | input | TXW | Tile column holding the top vertex |
| out_valid | output | 1 | Tile result available |
| out_ready | input | 1 | Consumer takes the tile |
| out_tx | output | TXW | Tile column of the result |
| out_ty | output | TYW | Tile row of the result |
| out_mask | output | 32 | Pixel coverage map of the tile |

## Verification
A wrong sweep direction, start column or row hand-over shows at the ports as an emitted tile sequence whose order or membership differs from the one derived from the triangle, and the first differing tile appears within one tile time, roughly a dozen cycles, of the fault. A corrupted edge accumulator in the column walk shows as wrong bits in that very tile's map, and a bad corner classification shows either as a missing tile or as an extra all-zero tile. A state machine that leaves idle too early or late shows as in_ready rising before the last tile or a tile arriving after in_ready rose.

// File: rtl/tile_raster_pkg.sv
package tile_raster_pkg;
  localparam int NUM_EDGES   = 3;
  localparam int TILE_W_LOG2 = 3;
  localparam int TILE_H_LOG2 = 2;
  localparam int TILE_W      = 1 << TILE_W_LOG2;
  localparam int TILE_H      = 1 << TILE_H_LOG2;
  localparam int TILE_PIX    = TILE_W * TILE_H;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_CLASS,
    ST_MASK,
    ST_SEND
  } walk_state_e;

  typedef enum logic {
    DIR_RIGHT,
    DIR_LEFT
  } sweep_dir_e;
endpackage

// File: rtl/tile_edge_eval.sv
// Evaluates the edge functions at a tile's top-left pixel (registered) and
// classifies the tile from its four corners.
module tile_edge_eval
  import tile_raster_pkg::*;
#(
  parameter int CW  = 24,
  parameter int TXW = 6,
  parameter int TYW = 6,
  parameter int EW  = 36
) (
  input  logic                    clk,
  input  logic [NUM_EDGES*CW-1:0] coef_a,
  input  logic [NUM_EDGES*CW-1:0] coef_b,
  input  logic [NUM_EDGES*CW-1:0] coef_c,
  input  logic [TXW-1:0]          tx,
  input  logic [TYW-1:0]          ty,
  output logic [NUM_EDGES*EW-1:0] e_org,
  output logic                    tile_outside
);
  logic signed [EW-1:0] px_s, py_s;
  logic [NUM_EDGES-1:0] edge_rejects;

  assign px_s = {{(EW-TXW-TILE_W_LOG2){1'b0}}, tx, {TILE_W_LOG2{1'b0}}};
  assign py_s = {{(EW-TYW-TILE_H_LOG2){1'b0}}, ty, {TILE_H_LOG2{1'b0}}};

  for (genvar k = 0; k < NUM_EDGES; k++) begin : gen_edge
    logic signed [EW-1:0] a_x, b_x, c_x, e_q;
    logic signed [EW-1:0] a_span, b_span;
    logic signed [EW-1:0] c_tr, c_bl, c_br;

    assign a_x = {{(EW-CW){coef_a[k*CW+CW-1]}}, coef_a[k*CW +: CW]};
    assign b_x = {{(EW-CW){coef_b[k*CW+CW-1]}}, coef_b[k*CW +: CW]};
    assign c_x = {{(EW-CW){coef_c[k*CW+CW-1]}}, coef_c[k*CW +: CW]};

    always_ff @(posedge clk) begin
      e_q <= a_x * px_s + b_x * py_s + c_x;
    end

    // corner offsets: (TILE_W-1)*A and (TILE_H-1)*B
    assign a_span = (a_x <<< TILE_W_LOG2) - a_x;
    assign b_span = (b_x <<< TILE_H_LOG2) - b_x;
    assign c_tr   = e_q + a_span;
    assign c_bl   = e_q + b_span;
    assign c_br   = c_tr + b_span;

    assign edge_rejects[k] = e_q[EW-1] & c_tr[EW-1] & c_bl[EW-1] & c_br[EW-1];
    assign e_org[k*EW +: EW] = e_q;
  end

  assign tile_outside = |edge_rejects;
endmodule

// File: rtl/tile_mask_walker.sv
// Builds a tile's pixel map column by column, one add of A per column step.
module tile_mask_walker
  import tile_raster_pkg::*;
#(
  parameter int CW = 24,
  parameter int EW = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [NUM_EDGES*EW-1:0] e_org,
  input  logic [NUM_EDGES*CW-1:0] coef_a,
  input  logic [NUM_EDGES*CW-1:0] coef_b,
  output logic                    busy,
  output logic                    done,
  output logic [TILE_PIX-1:0]     mask
);
  logic [TILE_W_LOG2-1:0]      col;
  logic [NUM_EDGES*TILE_H-1:0] neg;
  logic [TILE_H-1:0]           row_in;

  for (genvar k = 0; k < NUM_EDGES; k++) begin : gen_edge
    logic signed [EW-1:0] a_x, b_x, e_k, step_a;
    logic signed [EW-1:0] roff [TILE_H];

    assign a_x = {{(EW-CW){coef_a[k*CW+CW-1]}}, coef_a[k*CW +: CW]};
    assign b_x = {{(EW-CW){coef_b[k*CW+CW-1]}}, coef_b[k*CW +: CW]};
    assign e_k = e_org[k*EW +: EW];

    always_comb begin
      roff[0] = '0;
      for (int r = 1; r < TILE_H; r++) roff[r] = roff[r-1] + b_x;
    end

    always_ff @(posedge clk) begin
      if (start) step_a <= a_x;
    end

    for (genvar r = 0; r < TILE_H; r++) begin : gen_row
      logic signed [EW-1:0] cv;
      always_ff @(posedge clk) begin
        if (start)     cv <= e_k + roff[r];
        else if (busy) cv <= cv + step_a;
      end
      assign neg[k*TILE_H + r] = cv[EW-1];
    end
  end

  always_comb begin
    for (int r = 0; r < TILE_H; r++) begin
      row_in[r] = 1'b1;
      for (int k = 0; k < NUM_EDGES; k++) row_in[r] = row_in[r] & ~neg[k*TILE_H + r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      col  <= '0;
      mask <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        col  <= '0;
        mask <= '0;
      end else if (busy) begin
        for (int r = 0; r < TILE_H; r++) mask[r*TILE_W + int'(col)] <= row_in[r];
        col <= col + 1'b1;
        if (col == TILE_W_LOG2'(TILE_W-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R1: a finished map is announced only right after the column walk ends
  a_r1_done_after_walk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));
endmodule

// File: rtl/tile_walk_ctrl.sv
// Row-walking state machine and output register.
module tile_walk_ctrl
  import tile_raster_pkg::*;
#(
  parameter int TXW = 6,
  parameter int TYW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [TXW-1:0]      bb_x0,
  input  logic [TYW-1:0]      bb_y0,
  input  logic [TXW-1:0]      bb_x1,
  input  logic [TYW-1:0]      bb_y1,
  input  logic [TXW-1:0]      top_tx,
  input  logic                tile_outside,
  input  logic                walk_done,
  input  logic [TILE_PIX-1:0] walk_mask,
  output logic                walk_start,
  output logic [TXW-1:0]      cur_tx,
  output logic [TYW-1:0]      cur_ty,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [TXW-1:0]      out_tx,
  output logic [TYW-1:0]      out_ty,
  output logic [TILE_PIX-1:0] out_mask
);
  walk_state_e state;
  sweep_dir_e  dir, nxt_dir;
  logic [TXW-1:0] bx0_q, bx1_q, start_tx, last_tx, lt_eff, nxt_tx, clamp_tx;
  logic [TYW-1:0] by0_q, by1_q, nxt_ty;
  logic have_last, hl_eff, go_on, row_end, finish, advance;

  assign in_ready   = (state == ST_IDLE);
  assign walk_start = (state == ST_CLASS) && !tile_outside;
  assign advance    = ((state == ST_CLASS) && tile_outside) ||
                      ((state == ST_SEND) && out_ready);

  assign clamp_tx = (top_tx < bb_x0) ? bb_x0 : ((top_tx > bb_x1) ? bb_x1 : top_tx);

  // next tile position when the current one is finished
  always_comb begin
    hl_eff  = (state == ST_SEND) ? 1'b1 : have_last;
    lt_eff  = (state == ST_SEND) ? cur_tx : last_tx;
    go_on   = (state == ST_SEND);
    nxt_tx  = cur_tx;
    nxt_ty  = cur_ty;
    nxt_dir = dir;
    row_end = 1'b0;
    if (dir == DIR_RIGHT) begin
      if (go_on && cur_tx < bx1_q) begin
        nxt_tx = cur_tx + 1'b1;
      end else if (start_tx > bx0_q) begin
        nxt_tx  = start_tx - 1'b1;
        nxt_dir = DIR_LEFT;
      end else begin
        row_end = 1'b1;
      end
    end else begin
      if (go_on && cur_tx > bx0_q) nxt_tx = cur_tx - 1'b1;
      else                         row_end = 1'b1;
    end
    finish = row_end && (cur_ty == by1_q);
    if (row_end) begin
      nxt_ty  = cur_ty + 1'b1;
      nxt_tx  = hl_eff ? lt_eff : start_tx;
      nxt_dir = DIR_RIGHT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dir       <= DIR_RIGHT;
      out_valid <= 1'b0;
      out_tx    <= '0;
      out_ty    <= '0;
      out_mask  <= '0;
      cur_tx    <= '0;
      cur_ty    <= '0;
      start_tx  <= '0;
      last_tx   <= '0;
      have_last <= 1'b0;
      bx0_q     <= '0;
      bx1_q     <= '0;
      by0_q     <= '0;
      by1_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          bx0_q     <= bb_x0;
          bx1_q     <= bb_x1;
          by0_q     <= bb_y0;
          by1_q     <= bb_y1;
          start_tx  <= clamp_tx;
          cur_tx    <= clamp_tx;
          cur_ty    <= bb_y0;
          dir       <= DIR_RIGHT;
          have_last <= 1'b0;
          state     <= ST_EVAL;
        end
        ST_EVAL:  state <= ST_CLASS;
        ST_CLASS: if (!tile_outside) state <= ST_MASK;
        ST_MASK: if (walk_done) begin
          out_valid <= 1'b1;
          out_mask  <= walk_mask;
          out_tx    <= cur_tx;
          out_ty    <= cur_ty;
          state     <= ST_SEND;
        end
        ST_SEND: if (out_ready) out_valid <= 1'b0;
        default: state <= ST_IDLE;
      endcase

      if (advance) begin
        last_tx <= lt_eff;
        if (finish) begin
          state <= ST_IDLE;
        end else begin
          cur_tx    <= nxt_tx;
          cur_ty    <= nxt_ty;
          dir       <= nxt_dir;
          start_tx  <= row_end ? nxt_tx : start_tx;
          have_last <= row_end ? 1'b0 : hl_eff;
          state     <= ST_EVAL;
        end
      end
    end
  end

  a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tx) && $stable(out_ty) && $stable(out_mask)));

  a_r6_tile_in_box: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_tx >= bx0_q && out_tx <= bx1_q && out_ty >= by0_q && out_ty <= by1_q));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));
endmodule

// File: rtl/tile_raster.sv
module tile_raster
  import tile_raster_pkg::*;
#(
  parameter int CW  = 24,
  parameter int TXW = 6,
  parameter int TYW = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NUM_EDGES*CW-1:0] coef_a,
  input  logic [NUM_EDGES*CW-1:0] coef_b,
  input  logic [NUM_EDGES*CW-1:0] coef_c,
  input  logic [TXW-1:0]          bb_x0,
  input  logic [TYW-1:0]          bb_y0,
  input  logic [TXW-1:0]          bb_x1,
  input  logic [TYW-1:0]          bb_y1,
  input  logic [TXW-1:0]          top_tx,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [TXW-1:0]          out_tx,
  output logic [TYW-1:0]          out_ty,
  output logic [TILE_PIX-1:0]     out_mask
);
  localparam int PXW = TXW + TILE_W_LOG2;
  localparam int EW  = CW + PXW + 3;

  logic [NUM_EDGES*CW-1:0] a_q, b_q, c_q;
  logic [NUM_EDGES*EW-1:0] e_org;
  logic [TXW-1:0] cur_tx;
  logic [TYW-1:0] cur_ty;
  logic [TILE_PIX-1:0] walk_mask;
  logic tile_outside, walk_start, walk_busy, walk_done, accept;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (accept) begin
      a_q <= coef_a;
      b_q <= coef_b;
      c_q <= coef_c;
    end
  end

  tile_edge_eval #(.CW(CW), .TXW(TXW), .TYW(TYW), .EW(EW)) u_eval (
    .clk(clk), .coef_a(a_q), .coef_b(b_q), .coef_c(c_q),
    .tx(cur_tx), .ty(cur_ty), .e_org(e_org), .tile_outside(tile_outside)
  );

  tile_mask_walker #(.CW(CW), .EW(EW)) u_walk (
    .clk(clk), .rst(rst), .start(walk_start), .e_org(e_org),
    .coef_a(a_q), .coef_b(b_q), .busy(walk_busy), .done(walk_done), .mask(walk_mask)
  );

  tile_walk_ctrl #(.TXW(TXW), .TYW(TYW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .bb_x0(bb_x0), .bb_y0(bb_y0), .bb_x1(bb_x1), .bb_y1(bb_y1), .top_tx(top_tx),
    .tile_outside(tile_outside), .walk_done(walk_done), .walk_mask(walk_mask),
    .walk_start(walk_start), .cur_tx(cur_tx), .cur_ty(cur_ty),
    .out_ready(out_ready), .out_valid(out_valid), .out_tx(out_tx),
    .out_ty(out_ty), .out_mask(out_mask)
  );

  // R7: the column walker is never restarted while it is still working
  a_r7_walk_exclusive: assert property (@(posedge clk) disable iff (rst)
    walk_busy |-> !walk_start);
endmodule

// File: tb/tb_tile_raster.sv
module tb_tile_raster;
  localparam int CW = 24, TXW = 6, TYW = 6, NE = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [NE*CW-1:0] coef_a = '0, coef_b = '0, coef_c = '0;
  logic [TXW-1:0] bb_x0 = '0, bb_x1 = '0, top_tx = '0, out_tx;
  logic [TYW-1:0] bb_y0 = '0, bb_y1 = '0, out_ty;
  logic [31:0] out_mask;

  always #4 clk = ~clk;

  tile_raster #(.CW(CW), .TXW(TXW), .TYW(TYW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .bb_x0(bb_x0), .bb_y0(bb_y0), .bb_x1(bb_x1), .bb_y1(bb_y1), .top_tx(top_tx),
    .out_valid(out_valid), .out_ready(out_ready), .out_tx(out_tx),
    .out_ty(out_ty), .out_mask(out_mask)
  );

  int n_checks = 0, n_fail = 0, wd = 0;
  longint ca[NE], cb[NE], cc[NE];
  int bx0, bx1, by0, by1, ttx;
  int exp_tx[256], exp_ty[256], got_tx[256], got_ty[256], n_exp, n_got;
  logic [31:0] exp_mask[256], got_mask[256];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  function automatic bit pin(int k, longint x, longint y);
    return (ca[k]*x + cb[k]*y + cc[k]) >= 0;
  endfunction

  function automatic bit tile_drop(int tx, int ty);
    for (int k = 0; k < NE; k++)
      if (!pin(k, 8*tx, 4*ty) && !pin(k, 8*tx+7, 4*ty) &&
          !pin(k, 8*tx, 4*ty+3) && !pin(k, 8*tx+7, 4*ty+3)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] tile_map(int tx, int ty);
    logic [31:0] m = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        m[r*8+c] = pin(0, 8*tx+c, 4*ty+r) && pin(1, 8*tx+c, 4*ty+r) && pin(2, 8*tx+c, 4*ty+r);
    return m;
  endfunction

  function automatic void push(int tx, int ty);
    exp_tx[n_exp] = tx;
    exp_ty[n_exp] = ty;
    exp_mask[n_exp] = tile_map(tx, ty);
    n_exp++;
  endfunction

  // expected tile sequence from R2..R6
  function automatic void build_expected();
    int st, tx;
    bit have;
    int last;
    n_exp = 0;
    st = (ttx < bx0) ? bx0 : ((ttx > bx1) ? bx1 : ttx);
    for (int ty = by0; ty <= by1; ty++) begin
      have = 0;
      last = st;
      tx = st;
      while (!tile_drop(tx, ty)) begin
        push(tx, ty); have = 1; last = tx;
        if (tx == bx1) break;
        tx++;
      end
      if (st > bx0) begin
        tx = st - 1;
        while (!tile_drop(tx, ty)) begin
          push(tx, ty); have = 1; last = tx;
          if (tx == bx0) break;
          tx--;
        end
      end
      if (have) st = last;
    end
  endfunction

  function automatic void set_tri(int x0, int y0, int x1, int y1, int x2, int y2);
    int xs[3], ys[3];
    xs = '{x0, x1, x2};
    ys = '{y0, y1, y2};
    for (int k = 0; k < NE; k++) begin
      int i = k, j = (k+1)%3, o = (k+2)%3;
      ca[k] = ys[i] - ys[j];
      cb[k] = xs[j] - xs[i];
      cc[k] = longint'(xs[i])*ys[j] - longint'(xs[j])*ys[i];
      if (ca[k]*xs[o] + cb[k]*ys[o] + cc[k] < 0) begin
        ca[k] = -ca[k]; cb[k] = -cb[k]; cc[k] = -cc[k];
      end
    end
    bx0 = ((x0 < x1 ? (x0 < x2 ? x0 : x2) : (x1 < x2 ? x1 : x2))) / 8;
    bx1 = ((x0 > x1 ? (x0 > x2 ? x0 : x2) : (x1 > x2 ? x1 : x2))) / 8;
    by0 = ((y0 < y1 ? (y0 < y2 ? y0 : y2) : (y1 < y2 ? y1 : y2))) / 4;
    by1 = ((y0 > y1 ? (y0 > y2 ? y0 : y2) : (y1 > y2 ? y1 : y2))) / 4;
    ttx = ((y0 <= y1 && y0 <= y2) ? x0 : ((y1 <= y2) ? x1 : x2)) / 8;
  endfunction

  function automatic void set_flat(longint a, longint b, longint c);
    for (int k = 0; k < NE; k++) begin
      ca[k] = a; cb[k] = b; cc[k] = c;
    end
  endfunction

  // drives one triangle, collects every tile, compares with the model
  task automatic run_case(input string req, input int slow);
    int cyc = 0;
    bit stalled = 0;
    int s_tx = 0, s_ty = 0;
    logic [31:0] s_m = '0;
    build_expected();
    n_got = 0;
    @(negedge clk);
    for (int k = 0; k < NE; k++) begin
      coef_a[k*CW +: CW] = ca[k][CW-1:0];
      coef_b[k*CW +: CW] = cb[k][CW-1:0];
      coef_c[k*CW +: CW] = cc[k][CW-1:0];
    end
    bb_x0 = TXW'(bx0); bb_x1 = TXW'(bx1); bb_y0 = TYW'(by0); bb_y1 = TYW'(by1);
    top_tx = TXW'(ttx);
    chk(in_ready === 1'b1, "R7", "in_ready before offer", longint'(in_ready), 1);
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b0, "R7", "in_ready after accept", longint'(in_ready), 0);
    coef_a = '1; coef_c = '1; bb_x0 = '0; bb_x1 = '1; top_tx = '0;
    while (1) begin
      out_ready = (slow == 0) || (cyc % 3 == 2);
      if (stalled)
        chk(out_valid === 1'b1 && out_tx == TXW'(s_tx) && out_ty == TYW'(s_ty) && out_mask == s_m,
            "R8", "held tile", longint'(out_mask), longint'(s_m));
      stalled = out_valid && !out_ready;
      if (stalled) begin
        s_tx = out_tx; s_ty = out_ty; s_m = out_mask;
      end
      if (out_valid && out_ready && n_got < 256) begin
        got_tx[n_got] = out_tx; got_ty[n_got] = out_ty; got_mask[n_got] = out_mask;
        n_got++;
      end
      if (cyc == 1) in_valid = 1'b0;
      if (in_ready && !out_valid && cyc > 0) break;
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        chk(0, req, "case timeout", cyc, 0);
        break;
      end
    end
    out_ready = 1'b0;
    chk(n_got == n_exp, req, "tile count", n_got, n_exp);
    for (int i = 0; i < n_got && i < n_exp; i++) begin
      chk(got_tx[i] == exp_tx[i] && got_ty[i] == exp_ty[i], req, "tile position (R4 R5 R6)",
          (longint'(got_ty[i]) << 16) | got_tx[i], (longint'(exp_ty[i]) << 16) | exp_tx[i]);
      chk(got_mask[i] == exp_mask[i], "R1", "pixel map", longint'(got_mask[i]), longint'(exp_mask[i]));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready === 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
  endtask

  task automatic t_small();   // R1: triangle inside one tile
    set_tri(2, 1, 6, 1, 3, 3);
    run_case("R1", 0);
  endtask

  task automatic t_large();   // R4 R5 R6: many rows, ragged edges
    set_tri(10, 3, 70, 30, 2, 40);
    run_case("R4", 0);
  endtask

  task automatic t_backpressure();  // R8 with a slow consumer
    set_tri(40, 2, 5, 22, 60, 27);
    run_case("R8", 1);
  endtask

  task automatic t_clamp_high();   // R3 R5: full cover, top column right of box
    set_flat(0, 0, 5);
    bx0 = 2; bx1 = 5; by0 = 1; by1 = 3; ttx = 9;
    run_case("R3", 0);
    chk(n_got > 0 && got_tx[0] == 5 && got_ty[0] == 1, "R3", "first tile clamped",
        n_got > 0 ? got_tx[0] : -1, 5);
  endtask

  task automatic t_clamp_low();    // R3: top column left of box
    set_flat(0, 0, 1);
    bx0 = 3; bx1 = 4; by0 = 0; by1 = 1; ttx = 0;
    run_case("R3", 0);
    chk(n_got > 0 && got_tx[0] == 3, "R3", "first tile low clamp",
        n_got > 0 ? got_tx[0] : -1, 3);
  endtask

  task automatic t_empty();   // R2: every tile dropped
    set_flat(0, 0, -1);
    bx0 = 1; bx1 = 3; by0 = 2; by1 = 2; ttx = 2;
    run_case("R2", 0);
    chk(n_got == 0, "R2", "no tiles for empty triangle", n_got, 0);
  endtask

  task automatic t_zero_map();  // R2: tile kept although no pixel inside
    ca[0] = 1;  cb[0] = 0; cc[0] = -3;
    ca[1] = -1; cb[1] = 0; cc[1] = 2;
    ca[2] = 0;  cb[2] = 0; cc[2] = 0;
    bx0 = 0; bx1 = 1; by0 = 0; by1 = 0; ttx = 0;
    run_case("R2", 0);
    chk(n_got == 1 && got_mask[0] == 32'h0, "R2", "all-zero map forwarded",
        n_got == 1 ? longint'(got_mask[0]) : -1, 0);
  endtask

  initial begin
    t_reset();
    t_small();
    t_large();
    t_backpressure();
    t_clamp_high();
    t_clamp_low();
    t_empty();
    t_zero_map();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule